// File: doc/BRIEF.md
# Flash Programming Controller with Polling

This block is the programming side of a small on-chip code store, built from ordinary registers. A host presents an address, a data byte and a mode, then strobes an active-low program line. A write or lock-bit command starts when that line returns high. It then runs for a fixed number of timebase ticks on its own, while a ready flag reports that it is busy. While a write is pending, a verify read of the targeted byte returns a polling pattern instead of real data. This lets the host detect completion without watching the ready flag.

Clearing the store back to all ones needs a separate command. The program line is held low in erase mode for a set number of ticks. Programming can only clear bits, so erase is the only way back to a blank byte. Three fixed identification bytes can be read out in signature mode. Two protection bits, once programmed, suppress verify reads of the store until the next erase. All durations count pulses on the `tick` input, so a real timebase or a short test timebase can drive the same logic.

Top module: `flashprog_ctrl`

## Requirements
- R1: After reset, `ready` is 1, no protection bit is programmed, and a verify read of every byte returns FFh.
- R2: The `mode` encoding is 0 idle, 1 verify, 2 write, 3 erase, 4 signature and 5 lock program. A low-to-high transition of `prog_n` in write or lock mode while `ready` is 1 drops `ready` at that same clock edge. `ready` returns to 1 at the clock edge of the WRITE_TICKS-th `tick` pulse after the start.
- R3: A completed write stores the old byte AND `wdata`, so a byte write can only clear bits.
- R4: While a write is pending, a verify read of its target address returns the complement of the target value's bit 7 in bit 7, with bits 6..0 zero. Verify reads of any other address return the stored contents. True data is returned once `ready` is 1.
- R5: A transition of `prog_n` while `ready` is 0 is ignored. It neither starts a second write nor changes the completion time of the one in progress.
- R6: Holding `prog_n` low in erase mode for ERASE_TICKS `tick` pulses sets every byte to FFh and unprograms both protection bits. A shorter hold changes nothing.
- R7: In signature mode, reads at 030h, 031h and 032h return 1Eh, 51h and SIG_VPP_BYTE respectively. SIG_VPP_BYTE defaults to FFh and is 05h for the low-voltage variant. Every other address returns FFh.
- R8: A lock command programs protection bit 0 when `wdata[0]`=1 and bit 1 when `wdata[1]`=1. With either bit programmed, verify reads return 00h. Only erase unprograms them, and a lock command with `wdata[1:0]`=00 protects nothing.
- R9: `rdata` is registered and reflects the inputs one clock later. In idle, write, erase and lock modes it reads 00h.
- R10: A `prog_n` transition in verify, signature or erase mode starts no write: `ready` stays 1 and the contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Data byte for a write, protection mask for a lock command |
| mode | input | 3 | Operation select (see R2) |
| prog_n | input | 1 | Active-low program line |
| tick | input | 1 | One-cycle timebase pulse |
| rdata | output | 8 | Registered read data |
| ready | output | 1 | 1 when no write or lock command is pending |

## Verification
A read result is due one clock after its address and mode are applied, so the bench drives inputs just after a rising edge and samples after the next one. `ready` falls at the edge that sees `prog_n` high after being low. It rises at the edge carrying the WRITE_TICKS-th tick, and the bench checks it one tick before that boundary and again on it. An erase takes effect at the edge of the ERASE_TICKS-th tick, so the bench tests a hold one tick short and then a full hold. Random writes over a small address window are checked against a bench model for both the polling value and the final byte.

// File: rtl/flashprog_pkg.sv
// Shared mode encoding and fixed signature constants for the flash
// programming controller. Assumes a 3-bit mode field on the top ports.
package flashprog_pkg;

    typedef enum logic [2:0] {
        FM_IDLE   = 3'd0,
        FM_VERIFY = 3'd1,
        FM_WRITE  = 3'd2,
        FM_ERASE  = 3'd3,
        FM_SIG    = 3'd4,
        FM_LOCK   = 3'd5
    } fp_mode_e;

    localparam int         SIG_ADDR_MAKER = 'h30;
    localparam int         SIG_ADDR_PART  = 'h31;
    localparam int         SIG_ADDR_VPP   = 'h32;
    localparam logic [7:0] SIG_MAKER      = 8'h1E;
    localparam logic [7:0] SIG_PART       = 8'h51;
    localparam logic [7:0] ERASED_BYTE    = 8'hFF;

endpackage

// File: rtl/fp_seq.sv
// Self-timed sequencer for byte writes and lock-bit commands.
// Latches the target on a start request when idle and counts WRITE_TICKS
// timebase pulses. Assumes tick is a single-cycle pulse.
module fp_seq #(
    parameter int ADDR_W      = 10,
    parameter int WRITE_TICKS = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start_write,
    input  logic              start_lock,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        cur_byte,
    output logic              busy,
    output logic              is_lock,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        tgt_data,
    output logic              done
);
    localparam int            CW   = $clog2(WRITE_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WRITE_TICKS - 1);

    logic [CW-1:0] cnt;

    // Completion strobe: the final tick of a pending command.
    assign done = busy && tick && (cnt == LAST);

    // Start, count and finish a pending write or lock command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            is_lock  <= 1'b0;
            cnt      <= '0;
            tgt_addr <= '0;
            tgt_data <= 8'h00;
        end else if (!busy && (start_write || start_lock)) begin
            busy     <= 1'b1;
            is_lock  <= start_lock;
            cnt      <= '0;
            tgt_addr <= addr;
            tgt_data <= start_lock ? {6'h3F, ~wdata[1:0]} : (cur_byte & wdata);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy && tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R2: without a tick the pending command cannot end.
    a_r2_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> busy);

    // R2: a start request when idle always makes the block busy.
    a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_write) |=> busy);

    // R5: the latched target does not move while a command is pending.
    a_r5_target_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(tgt_addr) && $stable(tgt_data)));

endmodule

// File: rtl/fp_erase_timer.sv
// Hold-low timer for chip erase. Counts ticks while the hold condition
// stays true and fires once when ERASE_TICKS have elapsed. Dropping the
// hold clears the count. Assumes tick is a single-cycle pulse.
module fp_erase_timer #(
    parameter int ERASE_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hold,
    output logic fire
);
    localparam int            EW   = $clog2(ERASE_TICKS + 1);
    localparam logic [EW-1:0] LAST = EW'(ERASE_TICKS - 1);

    logic [EW-1:0] cnt;
    logic          fired;

    // Erase strobe on the tick that completes the hold window.
    assign fire = hold && tick && !fired && (cnt == LAST);

    // Count the hold window and remember that this hold already erased.
    always_ff @(posedge clk) begin
        if (!rst_n || !hold) begin
            cnt   <= '0;
            fired <= 1'b0;
        end else if (tick && !fired) begin
            if (cnt == LAST) fired <= 1'b1;
            else             cnt   <= cnt + 1'b1;
        end
    end

    // R6: one hold produces at most one erase strobe in a row.
    a_r6_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/fp_array.sv
// Register-based code store with protection bits and the registered read
// path. Handles erase, write commit, lock commit, data polling, signature
// bytes and lock-based suppression of verify reads.
module fp_array
    import flashprog_pkg::*;
#(
    parameter int         ADDR_W       = 10,
    parameter logic [7:0] SIG_VPP_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fp_mode_e          mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic              erase,
    input  logic              commit,
    input  logic              is_lock,
    input  logic              busy,
    input  logic [ADDR_W-1:0] tgt_addr,
    input  logic [7:0]        tgt_data,
    output logic [7:0]        cur_byte,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];
    logic [1:0] lock;  // 1 = unprogrammed
    logic       polling;
    logic [7:0] sig_byte;

    assign cur_byte = mem[addr];
    assign polling  = busy && !is_lock && (addr == tgt_addr);

    // Signature byte select for the current address.
    always_comb begin
        if (addr == ADDR_W'(SIG_ADDR_MAKER))     sig_byte = SIG_MAKER;
        else if (addr == ADDR_W'(SIG_ADDR_PART)) sig_byte = SIG_PART;
        else if (addr == ADDR_W'(SIG_ADDR_VPP))  sig_byte = SIG_VPP_BYTE;
        else                                     sig_byte = ERASED_BYTE;
    end

    // Store contents: erased at reset and on erase, written on commit.
    always_ff @(posedge clk) begin
        if (!rst_n || erase) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
        end else if (commit && !is_lock) begin
            mem[tgt_addr] <= tgt_data;
        end
    end

    // Protection bits: cleared by lock commit, restored only by erase.
    always_ff @(posedge clk) begin
        if (!rst_n || erase)      lock <= 2'b11;
        else if (commit && is_lock) lock <= lock & tgt_data[1:0];
    end

    // Registered read path selected by mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else begin
            case (mode)
                FM_SIG:    rdata <= sig_byte;
                FM_VERIFY: begin
                    if (polling)             rdata <= {~tgt_data[7], 7'h00};
                    else if (lock != 2'b11)  rdata <= 8'h00;
                    else                     rdata <= mem[addr];
                end
                default:   rdata <= 8'h00;
            endcase
        end
    end

    // R8: a protection bit never returns to unprogrammed without erase.
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !erase |=> ((lock & ~$past(lock)) == 2'b00));

    // R4: a verify read of the pending target returns the polling pattern.
    a_r4_poll_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == FM_VERIFY && busy && !is_lock && addr == tgt_addr)
        |=> (rdata == {~$past(tgt_data[7]), 7'h00}));

endmodule

// File: rtl/flashprog_ctrl.sv
// Top of the flash programming controller. Detects the rising edge of the
// active-low program line, routes start requests to the sequencer, gates
// the erase hold timer and connects the store. Assumes all inputs are
// synchronous to clk.
module flashprog_ctrl
    import flashprog_pkg::*;
#(
    parameter int         ADDR_W       = 10,
    parameter int         WRITE_TICKS  = 15,
    parameter int         ERASE_TICKS  = 100,
    parameter logic [7:0] SIG_VPP_BYTE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic [2:0]        mode,
    input  logic              prog_n,
    input  logic              tick,
    output logic [7:0]        rdata,
    output logic              ready
);
    fp_mode_e          mode_e;
    logic              prog_q;
    logic              prog_rise;
    logic              busy;
    logic              is_lock;
    logic              done;
    logic              erase_fire;
    logic [ADDR_W-1:0] tgt_addr;
    logic [7:0]        tgt_data;
    logic [7:0]        cur_byte;

    assign mode_e    = fp_mode_e'(mode);
    assign prog_rise = prog_n && !prog_q;
    assign ready     = !busy;

    // Previous level of the program line for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= 1'b1;
        else        prog_q <= prog_n;
    end

    fp_seq #(
        .ADDR_W      (ADDR_W),
        .WRITE_TICKS (WRITE_TICKS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .start_write (prog_rise && mode_e == FM_WRITE),
        .start_lock  (prog_rise && mode_e == FM_LOCK),
        .addr        (addr),
        .wdata       (wdata),
        .cur_byte    (cur_byte),
        .busy        (busy),
        .is_lock     (is_lock),
        .tgt_addr    (tgt_addr),
        .tgt_data    (tgt_data),
        .done        (done)
    );

    fp_erase_timer #(
        .ERASE_TICKS (ERASE_TICKS)
    ) u_erase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hold  (mode_e == FM_ERASE && !prog_n && !busy),
        .fire  (erase_fire)
    );

    fp_array #(
        .ADDR_W       (ADDR_W),
        .SIG_VPP_BYTE (SIG_VPP_BYTE)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_e),
        .addr     (addr),
        .erase    (erase_fire),
        .commit   (done),
        .is_lock  (is_lock),
        .busy     (busy),
        .tgt_addr (tgt_addr),
        .tgt_data (tgt_data),
        .cur_byte (cur_byte),
        .rdata    (rdata)
    );

endmodule

// File: tb/flashprog_ctrl_bench.sv
module flashprog_ctrl_bench;
    localparam int AW = 10;
    localparam int WT = 4;
    localparam int ET = 6;

    localparam logic [2:0] M_IDLE = 3'd0, M_VER = 3'd1, M_WR = 3'd2,
                           M_ER = 3'd3, M_SIG = 3'd4, M_LOCK = 3'd5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = 8'h00;
    logic [2:0]    mode = M_IDLE;
    logic          prog_n = 1'b1;
    logic          tick = 1'b0;
    logic [7:0]    rdata;
    logic          ready;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] mdl [1024];

    always #10 clk = ~clk;

    flashprog_ctrl #(.ADDR_W(AW), .WRITE_TICKS(WT), .ERASE_TICKS(ET)) u_flashprog_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .mode(mode),
        .prog_n(prog_n), .tick(tick), .rdata(rdata), .ready(ready));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic ticks(input int k);
        for (int i = 0; i < k; i++) begin
            tick = 1'b1; step(); tick = 1'b0; step();
        end
    endtask

    task automatic rd(input logic [2:0] m, input logic [AW-1:0] a, output logic [7:0] d);
        mode = m; addr = a; step(); d = rdata;
    endtask

    task automatic pulse(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d);
        mode = m; addr = a; wdata = d; prog_n = 1'b0; step();
        prog_n = 1'b1; step();
    endtask

    function automatic logic [7:0] poll_val(input logic [7:0] v);
        return {~v[7], 7'h00};
    endfunction

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] d;
        logic [7:0] nv;
        logic [AW-1:0] a;
        int unsigned sd;
        sd = $urandom(32'd2024);
        for (int i = 0; i < 1024; i++) mdl[i] = 8'hFF;
        repeat (3) step();
        rst_n = 1'b1; step();

        // R1 reset state
        chk("R1 ready", {7'h0, ready}, 8'h01);
        rd(M_VER, 10'd0, d);    chk("R1 byte 0", d, 8'hFF);
        rd(M_VER, 10'd1023, d); chk("R1 top byte", d, 8'hFF);
        // R9 idle mode
        rd(M_IDLE, 10'd0, d);   chk("R9 idle read", d, 8'h00);
        // R7 signature
        rd(M_SIG, 10'h30, d);   chk("R7 sig 030", d, 8'h1E);
        rd(M_SIG, 10'h31, d);   chk("R7 sig 031", d, 8'h51);
        rd(M_SIG, 10'h32, d);   chk("R7 sig 032", d, 8'hFF);
        rd(M_SIG, 10'h33, d);   chk("R7 sig other", d, 8'hFF);

        // R2 / R4 timed write with polling
        pulse(M_WR, 10'd5, 8'h3C);
        chk("R2 busy at start", {7'h0, ready}, 8'h00);
        rd(M_WR, 10'd5, d);     chk("R9 write-mode read", d, 8'h00);
        rd(M_VER, 10'd5, d);    chk("R4 poll target", d, 8'h80);
        rd(M_VER, 10'd6, d);    chk("R4 other address", d, 8'hFF);
        ticks(WT - 1);
        chk("R2 still busy", {7'h0, ready}, 8'h00);
        ticks(1);
        chk("R2 ready after last tick", {7'h0, ready}, 8'h01);
        rd(M_VER, 10'd5, d);    chk("R4 true data", d, 8'h3C);
        mdl[5] = 8'h3C;

        // R3 bits only clear
        pulse(M_WR, 10'd5, 8'hC3); ticks(WT);
        rd(M_VER, 10'd5, d);    chk("R3 and result", d, 8'h00);
        pulse(M_WR, 10'd5, 8'hFF); ticks(WT);
        rd(M_VER, 10'd5, d);    chk("R3 no raise", d, 8'h00);
        mdl[5] = 8'h00;

        // R5 pulse while busy ignored
        pulse(M_WR, 10'd20, 8'h7E);
        ticks(1);
        pulse(M_WR, 10'd21, 8'h11);
        ticks(WT - 2);
        chk("R5 busy unchanged", {7'h0, ready}, 8'h00);
        ticks(1);
        chk("R5 completes on time", {7'h0, ready}, 8'h01);
        rd(M_VER, 10'd21, d);   chk("R5 second target untouched", d, 8'hFF);
        rd(M_VER, 10'd20, d);   chk("R5 first target", d, 8'h7E);
        mdl[20] = 8'h7E;

        // R10 pulses in other modes start nothing
        pulse(M_VER, 10'd30, 8'h00);
        chk("R10 verify pulse", {7'h0, ready}, 8'h01);
        pulse(M_SIG, 10'd30, 8'h00);
        chk("R10 sig pulse", {7'h0, ready}, 8'h01);
        pulse(M_ER, 10'd30, 8'h00);
        chk("R10 erase pulse", {7'h0, ready}, 8'h01);
        rd(M_VER, 10'd30, d);   chk("R10 contents kept", d, 8'hFF);

        // Random writes over a small window (R3, R4)
        for (int k = 0; k < 24; k++) begin
            a  = AW'($urandom_range(0, 31));
            nv = 8'($urandom);
            pulse(M_WR, a, nv);
            mdl[a] = mdl[a] & nv;
            rd(M_VER, a, d);    chk("R4 random poll", d, poll_val(mdl[a]));
            ticks(WT);
            rd(M_VER, a, d);    chk("R3 random write", d, mdl[a]);
        end

        // R6 short hold does nothing, full hold erases
        mode = M_ER; prog_n = 1'b0; step();
        ticks(ET - 1);
        prog_n = 1'b1; step();
        rd(M_VER, 10'd5, d);    chk("R6 short hold", d, 8'h00);
        rd(M_ER, 10'd5, d);     chk("R9 erase-mode read", d, 8'h00);
        mode = M_ER; prog_n = 1'b0; step();
        ticks(ET);
        prog_n = 1'b1; step();
        rd(M_VER, 10'd5, d);    chk("R6 erased", d, 8'hFF);
        rd(M_VER, 10'd20, d);   chk("R6 erased other", d, 8'hFF);
        for (int i = 0; i < 1024; i++) mdl[i] = 8'hFF;

        // R8 lock bits
        pulse(M_WR, 10'd7, 8'h12); ticks(WT);
        pulse(M_LOCK, 10'd0, 8'h00); ticks(WT);
        rd(M_VER, 10'd7, d);    chk("R8 empty mask", d, 8'h12);
        pulse(M_LOCK, 10'd0, 8'h01);
        chk("R2 lock busy", {7'h0, ready}, 8'h00);
        rd(M_LOCK, 10'd0, d);   chk("R9 lock-mode read", d, 8'h00);
        ticks(WT);
        rd(M_VER, 10'd7, d);    chk("R8 bit0 blocks", d, 8'h00);
        rd(M_SIG, 10'h31, d);   chk("R8 sig still readable", d, 8'h51);
        mode = M_ER; prog_n = 1'b0; step();
        ticks(ET);
        prog_n = 1'b1; step();
        rd(M_VER, 10'd7, d);    chk("R8 erase unlocks", d, 8'hFF);
        pulse(M_LOCK, 10'd0, 8'h02); ticks(WT);
        rd(M_VER, 10'd7, d);    chk("R8 bit1 blocks", d, 8'h00);

        finish_up();
    end
endmodule